// File: doc/BRIEF.md
# Page-Write Load Controller

This block sits in front of a byte-wide, page-organised nonvolatile memory. It samples the active-low chip-enable, write-enable and output-enable strobes on the system clock and turns each qualified write strobe into one byte-load. Each byte-load goes into a page staging buffer. The address is taken when the strobe pulse opens and the data when it closes.

A page-load session begins with the first accepted byte. It stays open while each new pulse opens within a short gap limit after the previous pulse closed. The session ends once the strobes stay quiet for a longer closing timeout. The block then runs a write of fixed length, and at the end of it the whole staged page is committed in one cycle to a register-based array model. Bytes that were never loaded in the session are written as FFH. The target page is the page address of the last byte loaded.

While the write runs, the block raises a busy flag and publishes the address of the last loaded byte, so that a status unit can answer polling reads. It ignores all strobe activity during this time. Timer lengths and the minimum strobe width are parameters counted in clock cycles.

Top module: `pgw_load_ctrl`

## Requirements
- R1: After reset, busy and loading are 0 and every array byte reads FFH.
- R2: A loaded byte lands in the array at page address addr[ADDR_W-1:7] and byte offset addr[6:0], and reads back there once the write completes.
- R3: Each session presets all 128 staged bytes to FFH. Any offset not loaded in the session is written as FFH, replacing older contents of that page.
- R4: Loading an offset that was already loaded in the same session replaces the staged byte. The last value wins.
- R5: The whole staged page goes to the page address of the last byte loaded, even when earlier bytes carried a different page address.
- R6: The session closes, and busy rises, about T_BLCO cycles after the last accepted pulse ends. Before that point loading stays 1 and busy stays 0.
- R7: A pulse that opens more than T_BLC cycles after the previous pulse closed is not loaded. The session still closes on the original timeout.
- R8: Busy is high for exactly T_WC cycles. Strobe pulses during busy are not loaded and do not open a new session.
- R9: A write pulse is counted only if CE# and WE# are both low, with OE# high, for at least MIN_PULSE sampled cycles. A pulse of exactly MIN_PULSE cycles is loaded.
- R10: No byte is loaded while OE# is low, while CE# is high, or while WE# is high.
- R11: The address is the one sampled in the first active cycle of a pulse. The data is the one sampled in its last active cycle.
- R12: last_addr shows the full address of the most recently accepted byte.
- R13: dout_en is 1 only when CE# and OE# are low and busy is 0. When it is 1, dout is the array byte at addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; bits 6:0 select the byte within a page |
| din | input | 8 | Write data |
| dout | output | 8 | Array byte at addr |
| dout_en | output | 1 | Array read data valid on dout |
| busy | output | 1 | Internal page write in progress |
| loading | output | 1 | Page-load session open |
| last_addr | output | ADDR_W | Address of the last accepted byte |

## Verification
The embedded assertions check, on every cycle, the rules that hold without reference to stored data. A held pulse keeps a session from closing. The target page stays fixed while busy. A fresh session starts with exactly one loaded byte. Reads are masked during busy. A close only follows a full-width pulse. The bench alone can show what actually reaches the array. It sweeps all pages with offset patterns and compares every array byte against an arithmetic model, which covers FFH fill, overwrite, last-page targeting, late and short pulses, inhibited strobes and pulses during busy.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
// Shared types for the page-write load controller.
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_WRITE = 2'd2
    } pgw_state_t;
endpackage

// File: rtl/pgw_strobe_qual.sv
`timescale 1ns/1ps
// Strobe qualifier: registers the raw strobes, address and data once, then
// recognises a write pulse (CE# and WE# low, OE# high) lasting at least
// MIN_PULSE samples. It captures the address on the first active sample and
// the data on every active sample, so the last active value is held at the end.
// Assumes the strobes are already synchronous to clk or slow relative to it.
module pgw_strobe_qual #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              beg_stb,
    output logic              end_stb,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data
);
    localparam int RUN_W = $clog2(MIN_PULSE + 1);

    logic              s_ce, s_we, s_oe;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;
    logic              act;
    logic [RUN_W-1:0]  run_cnt;
    logic              q_on;

    // Sample the pins once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ce   <= 1'b1;
            s_we   <= 1'b1;
            s_oe   <= 1'b1;
            s_addr <= '0;
            s_din  <= '0;
        end else begin
            s_ce   <= ce_n;
            s_we   <= we_n;
            s_oe   <= oe_n;
            s_addr <= addr;
            s_din  <= din;
        end
    end

    assign act = !s_ce && !s_we && s_oe;

    // Count consecutive active samples, saturating at MIN_PULSE.
    always_ff @(posedge clk) begin
        if (!rst_n)                              run_cnt <= '0;
        else if (!act)                           run_cnt <= '0;
        else if (run_cnt != RUN_W'(MIN_PULSE))   run_cnt <= run_cnt + 1'b1;
    end

    assign beg_stb = act && (run_cnt == RUN_W'(MIN_PULSE - 1));

    // Remember that the current pulse has qualified.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_on <= 1'b0;
        else if (!act)    q_on <= 1'b0;
        else if (beg_stb) q_on <= 1'b1;
    end

    assign end_stb = q_on && !act;

    // Address from the opening sample of a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                         lat_addr <= '0;
        else if (act && run_cnt == '0)      lat_addr <= s_addr;
    end

    // Data follows the pulse and freezes at its last active sample.
    always_ff @(posedge clk) begin
        if (!rst_n)   lat_data <= '0;
        else if (act) lat_data <= s_din;
    end

    assert_end_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb |-> $past(act));
    assert_single_begin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beg_stb |=> !beg_stb);
endmodule

// File: rtl/pgw_load_fsm.sv
`timescale 1ns/1ps
// Session sequencer: accepts qualified pulses, times the gap limit (T_BLC),
// the closing timeout (T_BLCO) and the write length (T_WC), keeps the target
// page and last address, and pulses commit on the final write cycle.
// Assumes beg_stb/end_stb come in begin-then-end pairs from the qualifier.
module pgw_load_fsm
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 7,
    parameter int T_BLC  = 20000,
    parameter int T_BLCO = 40000,
    parameter int T_WC   = 1000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beg_stb,
    input  logic                    end_stb,
    input  logic [ADDR_W-1:0]       lat_addr,
    output logic                    buf_clr,
    output logic                    buf_wr,
    output logic [OFS_W-1:0]        wr_ofs,
    output logic [ADDR_W-OFS_W-1:0] page,
    output logic                    commit,
    output logic                    busy,
    output logic                    loading,
    output logic [ADDR_W-1:0]       last_addr
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int GAP_W  = $clog2(T_BLCO + 1);
    localparam int WC_W   = $clog2(T_WC + 1);

    pgw_state_t       state;
    logic [GAP_W-1:0] gap_cnt;
    logic [WC_W-1:0]  wc_cnt;
    logic             pulse_ok;
    logic             accept_beg;
    logic             take;
    logic             close;

    assign accept_beg = beg_stb && ((state == ST_IDLE) ||
                        (state == ST_LOAD && gap_cnt < GAP_W'(T_BLC)));
    assign take    = end_stb && pulse_ok;
    assign buf_wr  = take;
    assign buf_clr = take && (state == ST_IDLE);
    assign wr_ofs  = lat_addr[OFS_W-1:0];
    assign close   = (state == ST_LOAD) && !pulse_ok && (gap_cnt == GAP_W'(T_BLCO - 1));
    assign commit  = (state == ST_WRITE) && (wc_cnt == WC_W'(T_WC - 1));
    assign busy    = (state == ST_WRITE);
    assign loading = (state == ST_LOAD);

    // Track whether the pulse in flight was accepted as a byte-load.
    always_ff @(posedge clk) begin
        if (!rst_n)       pulse_ok <= 1'b0;
        else if (beg_stb) pulse_ok <= accept_beg;
        else if (end_stb) pulse_ok <= 1'b0;
    end

    // Gap timer: restarts on each accepted byte, frozen while a pulse is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          gap_cnt <= '0;
        else if (take || state != ST_LOAD)                   gap_cnt <= '0;
        else if (!pulse_ok && gap_cnt != GAP_W'(T_BLCO))     gap_cnt <= gap_cnt + 1'b1;
    end

    // Write timer: counts the cycles of the internal write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wc_cnt <= '0;
        else if (state != ST_WRITE) wc_cnt <= '0;
        else                        wc_cnt <= wc_cnt + 1'b1;
    end

    // Session state sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:  if (take)   state <= ST_LOAD;
                ST_LOAD:  if (close)  state <= ST_WRITE;
                ST_WRITE: if (commit) state <= ST_IDLE;
                default:              state <= ST_IDLE;
            endcase
        end
    end

    // Target page and last address follow every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page      <= '0;
            last_addr <= '0;
        end else if (take) begin
            page      <= lat_addr[ADDR_W-1:OFS_W];
            last_addr <= lat_addr;
        end
    end

    assert_hold_blocks_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && pulse_ok) |=> !busy);
    assert_page_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page));
    assert_no_take_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_wr);
    assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wc_cnt) == WC_W'(T_WC - 1));
endmodule

// File: rtl/pgw_page_buf.sv
`timescale 1ns/1ps
// Page staging buffer: one byte per offset plus a loaded mask. A clear presets
// every byte to FFH and empties the mask; a write in the same cycle still lands.
module pgw_page_buf #(
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           wr,
    input  logic [OFS_W-1:0]               ofs,
    input  logic [DATA_W-1:0]              data,
    output logic [(2**OFS_W)*DATA_W-1:0]   page_data
);
    localparam int NBYTES = 2 ** OFS_W;

    logic [NBYTES-1:0] mask;

    // Preset, overwrite or hold each staged byte.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NBYTES; i++) begin
            if (!rst_n)                         page_data[i*DATA_W +: DATA_W] <= '1;
            else if (wr && ofs == OFS_W'(i))    page_data[i*DATA_W +: DATA_W] <= data;
            else if (clr)                       page_data[i*DATA_W +: DATA_W] <= '1;
        end
    end

    // Loaded mask, emptied at the start of each session.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NBYTES; i++) begin
            if (!rst_n)                         mask[i] <= 1'b0;
            else if (wr && ofs == OFS_W'(i))    mask[i] <= 1'b1;
            else if (clr)                       mask[i] <= 1'b0;
        end
    end

    assert_fresh_session_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && wr) |=> $countones(mask) == 1);
    assert_write_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> mask[$past(ofs)]);
endmodule

// File: rtl/pgw_array.sv
`timescale 1ns/1ps
// Behavioural array: register storage, erased to FFH on reset, takes a whole
// staged page in one commit cycle, and reads combinationally.
module pgw_array #(
    parameter int ADDR_W = 10,
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic [ADDR_W-OFS_W-1:0]        page,
    input  logic [(2**OFS_W)*DATA_W-1:0]   page_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data
);
    localparam int DEPTH  = 2 ** ADDR_W;
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int NBYTES = 2 ** OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit every byte of the selected page at once.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (commit && page == PAGE_W'(i >> OFS_W))
                mem[i] <= page_data[(i % NBYTES)*DATA_W +: DATA_W];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pgw_load_ctrl.sv
`timescale 1ns/1ps
// Page-write load controller top: qualifier -> session sequencer -> staging
// buffer -> array. Reads are offered only outside the internal write; during
// busy the status unit owns the read path using busy and last_addr.
module pgw_load_ctrl #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 128,
    parameter int T_BLC      = 20000,
    parameter int T_BLCO     = 40000,
    parameter int T_WC       = 1000000,
    parameter int MIN_PULSE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy,
    output logic              loading,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int DATA_W = 8;
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic              beg_stb, end_stb;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              buf_clr, buf_wr, commit;
    logic [OFS_W-1:0]  wr_ofs;
    logic [PAGE_W-1:0] page;
    logic [PAGE_BYTES*DATA_W-1:0] page_data;

    pgw_strobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .beg_stb(beg_stb), .end_stb(end_stb),
        .lat_addr(lat_addr), .lat_data(lat_data));

    pgw_load_fsm #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .T_BLC(T_BLC),
                   .T_BLCO(T_BLCO), .T_WC(T_WC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .beg_stb(beg_stb), .end_stb(end_stb),
        .lat_addr(lat_addr), .buf_clr(buf_clr), .buf_wr(buf_wr), .wr_ofs(wr_ofs),
        .page(page), .commit(commit), .busy(busy), .loading(loading),
        .last_addr(last_addr));

    pgw_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr), .ofs(wr_ofs),
        .data(lat_data), .page_data(page_data));

    pgw_array #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .page(page),
        .page_data(page_data), .rd_addr(addr), .rd_data(dout));

    assign dout_en = !ce_n && !oe_n && !busy;

    assert_no_read_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dout_en);
    assert_not_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && loading));
endmodule

// File: tb/pgw_load_ctrl_tb.sv
`timescale 1ns/1ps
module pgw_load_ctrl_tb;
    localparam int AW = 9, PB = 128, TBLC = 20, TBLCO = 40, TWC = 30, MINP = 3;
    localparam int DEPTH = 2 ** AW;

    logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
    logic [AW-1:0] addr = '0, last_addr;
    logic [7:0] din = '0, dout;
    logic dout_en, busy, loading;

    int checks = 0, errors = 0;
    bit done = 0, open_pg = 0;
    logic [7:0] exp_mem [DEPTH];
    logic [7:0] pend [PB];
    logic [1:0] pend_page;

    always #2.5 clk = ~clk;

    pgw_load_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .T_BLC(TBLC), .T_BLCO(TBLCO),
                    .T_WC(TWC), .MIN_PULSE(MINP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy),
        .loading(loading), .last_addr(last_addr));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Raw write pulse of w active cycles, then a short idle gap.
    task automatic pulse(logic [AW-1:0] a, logic [7:0] d, int w);
        @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
        tick(w);
        we_n = 1; ce_n = 1;
        tick(3);
    endtask

    // Accepted byte-load: drive it and record it in the model.
    task automatic mload(logic [AW-1:0] a, logic [7:0] d);
        pulse(a, d, 5);
        if (!open_pg) begin
            for (int i = 0; i < PB; i++) pend[i] = 8'hFF;
            open_pg = 1;
        end
        pend[a[6:0]] = d;
        pend_page = a[8:7];
        check("R12 last_addr", int'(last_addr), int'(a));
    endtask

    task automatic read_chk(logic [AW-1:0] a, logic [7:0] e, string req);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
        @(negedge clk);
        check(req, {dout_en, dout}, {1'b1, e});
        ce_n = 1; oe_n = 1;
    endtask

    task automatic verify_all(string req);
        for (int a = 0; a < DEPTH; a++) read_chk(AW'(a), exp_mem[a], req);
    endtask

    // Wait for close, time the write, then apply the model.
    task automatic finish(bit win);
        int n = 0;
        if (win) begin
            tick(TBLCO - 10);
            check("R6 open before timeout", {busy, loading}, 2'b01);
        end
        while (!busy && n < 2 * TBLCO) begin @(negedge clk); n++; end
        check("R6 busy rose", int'(busy), 1);
        n = 0;
        while (busy && n < 4 * TWC) begin n++; @(negedge clk); end
        check("R8 busy length", n, TWC);
        for (int i = 0; i < PB; i++) exp_mem[{pend_page, 7'(i)}] = pend[i];
        open_pg = 0;
        check("R6 session ended", int'(loading), 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        tick(3); rst_n = 1; tick(2);
        check("R1 reset flags", {busy, loading, dout_en}, 3'b000);
        verify_all("R1 erased");

        // R2 R3: sweep every page with an offset stride pattern.
        for (int p = 0; p < 4; p++) begin
            for (int o = 0; o < PB; o += p + 3)
                mload({2'(p), 7'(o)}, 8'((p * 37 + o * 5 + 1) & 8'hFF));
            finish(1);
        end
        verify_all("R2 R3 sweep");

        // R3: reload page 1 with one byte; rest of page 1 becomes FFH.
        mload({2'd1, 7'd127}, 8'h3C);
        finish(1);
        verify_all("R3 refill");

        // R4: overwrite in one session.
        mload({2'd2, 7'd10}, 8'h11);
        mload({2'd2, 7'd10}, 8'h22);
        finish(1);
        read_chk({2'd2, 7'd10}, 8'h22, "R4 overwrite");

        // R5: last byte's page wins.
        mload({2'd0, 7'd5}, 8'hA5);
        mload({2'd3, 7'd6}, 8'h5A);
        finish(1);
        verify_all("R5 last page");

        // R11: address from pulse start, data from pulse end.
        @(negedge clk); addr = {2'd0, 7'd20}; din = 8'h01; ce_n = 0; we_n = 0;
        tick(4); addr = {2'd0, 7'd90}; din = 8'hEE;
        tick(3); we_n = 1; ce_n = 1; tick(3);
        for (int i = 0; i < PB; i++) pend[i] = 8'hFF;
        pend[20] = 8'hEE; pend_page = 2'd0; open_pg = 1;
        finish(1);
        verify_all("R11 latch points");

        // R9: short pulse ignored, exact-minimum pulse loaded.
        pulse({2'd1, 7'd0}, 8'h77, MINP - 1);
        tick(TBLCO + 10);
        check("R9 short pulse", {busy, loading}, 2'b00);
        read_chk({2'd1, 7'd0}, exp_mem[{2'd1, 7'd0}], "R9 short pulse no data");
        pulse({2'd1, 7'd0}, 8'h78, MINP);
        for (int i = 0; i < PB; i++) pend[i] = 8'hFF;
        pend[0] = 8'h78; pend_page = 2'd1; open_pg = 1;
        finish(0);
        verify_all("R9 min pulse");

        // R10: inhibit conditions.
        @(negedge clk); addr = {2'd2, 7'd1}; din = 8'h66;
        ce_n = 0; we_n = 0; oe_n = 0; tick(6); ce_n = 1; we_n = 1; oe_n = 1;
        ce_n = 1; we_n = 0; tick(6); we_n = 1;
        ce_n = 0; we_n = 1; tick(6); ce_n = 1;
        tick(TBLCO + 10);
        check("R10 inhibit", {busy, loading}, 2'b00);
        read_chk({2'd2, 7'd1}, exp_mem[{2'd2, 7'd1}], "R10 inhibit data");

        // R7: late pulse dropped, page closes on the original timeout.
        mload({2'd0, 7'd0}, 8'h33);
        tick(TBLC + 4);
        pulse({2'd0, 7'd1}, 8'h44, 5);
        finish(0);
        verify_all("R7 late byte");

        // R8 R13: strobes and reads during busy.
        mload({2'd3, 7'd2}, 8'h99);
        while (!busy) @(negedge clk);
        pulse({2'd1, 7'd3}, 8'h55, 5);
        @(negedge clk); ce_n = 0; oe_n = 0;
        @(negedge clk); check("R13 read masked", int'(dout_en), 0);
        ce_n = 1; oe_n = 1;
        while (busy) @(negedge clk);
        for (int i = 0; i < PB; i++) exp_mem[{pend_page, 7'(i)}] = pend[i];
        open_pg = 0;
        tick(TBLCO + 10);
        check("R8 no session after busy", {busy, loading}, 2'b00);
        verify_all("R8 ignored during busy");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule